// File: doc/BRIEF.md
# External Bus Request Sequencer

The sequencer connects a processor core to one shared external 16-bit address and data bus. In a single cycle the core may raise up to three requests: a data write, a data read and an instruction fetch. The block captures whichever of these are present as one batch. It then runs them one after another on the external bus. For each bus cycle it drives the address, one of three active-low space selects (program, data, I/O), a read/write direction line, a strobe, and separate active-low read and write enables. Each request is answered to the core with a one-cycle done pulse, and a read also returns its data.

A configuration register sets how much of the top of data space counts as global memory. An access into that region pulls a bus-request line low for its whole duration. The access is then held with wait states until the external side raises READY. Every other access ignores READY: reads take one bus cycle and writes take two. The core sees a busy flag while a batch is running, and requests raised during that time are dropped.

Top module: `xbus_sequencer`

## Requirements
- R1: After reset, and whenever no transaction is running, strb_n, ps_n, ds_n, is_n, rd_n, we_n and br_n are all high, seq_busy and every done output are low, and the global-mapping register holds zero, so that no address is global.
- R2: Requests captured together run on the bus in a fixed order: the data write first, then the data read, then the fetch. Each transaction begins in the cycle right after the previous one ends, and the first bus cycle is the cycle after the capture edge.
- R3: A request kind absent from a batch is skipped, and the next present kind starts with no gap.
- R4: A non-global read occupies one bus cycle with strb_n=0, rd_n=0, rnw=1 and we_n=1. The bus data is sampled at the end of that cycle. The matching done output pulses for one cycle in the following cycle, and fetch_rdata or dread_rdata holds the sampled value until the next read of the same kind completes.
- R5: A non-global write occupies two bus cycles with strb_n=0 and rnw=0. The block drives dwrite_data on bus_data in both cycles. we_n is high in the first cycle and low in the second, and dwrite_done pulses in the cycle after the second. rd_n and we_n are never low together.
- R6: During every bus cycle exactly one select is low. A fetch uses ps_n. A data request with its I/O flag low uses ds_n. A data request with its I/O flag high uses is_n, with the same timing as a memory access.
- R7: Let N be the global-mapping register value, limited to 8. A data-space address is global when N is non-zero and its upper four address bits are at least 16-N. So N=2 makes 0xE000 to 0xFFFF global, and N of 8 or more makes 0x8000 to 0xFFFF global. Fetches and I/O accesses are never global.
- R8: br_n is low in every bus cycle of a global access, including the first, and high in every bus cycle of a non-global access.
- R9: A global read cycle, or the second cycle of a global write, repeats with the address held until READY is seen high at a clock edge. READY has no effect on non-global accesses.
- R10: seq_busy is high from the cycle after capture until the last transaction of the batch has finished. Requests raised while it is high are ignored.
- R11: A write on the gmap_we/gmap_wdata port loads the global-mapping register. Global decode uses the register value at the moment a batch is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gmap_we | input | 1 | Load strobe for the global-mapping register |
| gmap_wdata | input | 8 | New global-mapping value |
| fetch_req | input | 1 | Instruction fetch request |
| fetch_addr | input | 16 | Program-space fetch address |
| dread_req | input | 1 | Data read request |
| dread_addr | input | 16 | Data read address |
| dread_io | input | 1 | Data read targets I/O space |
| dwrite_req | input | 1 | Data write request |
| dwrite_addr | input | 16 | Data write address |
| dwrite_data | input | 16 | Data write value |
| dwrite_io | input | 1 | Data write targets I/O space |
| seq_busy | output | 1 | Batch in progress, new requests ignored |
| fetch_done | output | 1 | Fetch completed (one-cycle pulse) |
| fetch_rdata | output | 16 | Fetched word |
| dread_done | output | 1 | Data read completed (one-cycle pulse) |
| dread_rdata | output | 16 | Data read word |
| dwrite_done | output | 1 | Data write completed (one-cycle pulse) |
| bus_addr | output | 16 | External address |
| bus_data | inout | 16 | External bidirectional data |
| ps_n | output | 1 | Program space select, active low |
| ds_n | output | 1 | Data space select, active low |
| is_n | output | 1 | I/O space select, active low |
| rnw | output | 1 | High for read, low for write |
| strb_n | output | 1 | Low during every external bus cycle |
| rd_n | output | 1 | Read enable, active low |
| we_n | output | 1 | Write enable, active low |
| br_n | output | 1 | Global bus request, active low |
| ready | input | 1 | External ready for global accesses |

## Verification
The ordering logic is exercised with batches holding all three requests, with only a write and a fetch, with only a read, and with I/O-space requests. Comparing these batches shows whether the order is fixed, whether empty slots are skipped without a gap, and whether each kind drives the right select. Global decode is tried at a mapping of two blocks, at a value above the limit and at zero, with addresses placed on both sides of each boundary. Slow READY responses on global reads and writes, together with non-global accesses made while READY is low, show that wait states appear only where the decode calls for them. A batch with a fetch raised again while busy shows that such requests are dropped.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    localparam int AW    = 16;
    localparam int DW    = 16;
    localparam int NSLOT = 3;
    localparam int SW    = 2;

    localparam logic [SW-1:0] SL_WR = 2'd0;
    localparam logic [SW-1:0] SL_RD = 2'd1;
    localparam logic [SW-1:0] SL_FE = 2'd2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUS  = 1'b1
    } seq_st_e;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          io;
        logic          glob;
    } slot_t;

    typedef struct packed {
        seq_st_e              st;
        logic [NSLOT-1:0]     pend;
        logic [SW-1:0]        cur;
        logic                 ph;
        slot_t [NSLOT-1:0]    slot;
        logic [DW-1:0]        wdata;
        logic [NSLOT-1:0]     done;
        logic [DW-1:0]        rd_data;
        logic [DW-1:0]        fe_data;
    } seq_t;
endpackage

// File: rtl/xbus_gmap.sv
module xbus_gmap #(
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [GW-1:0] wdata,
    output logic [GW-1:0] gmap
);
    logic [GW-1:0] gmap_d, gmap_q;

    always_comb begin
        gmap_d = gmap_q;
        if (we) gmap_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gmap_q <= '0;
        else        gmap_q <= gmap_d;
    end

    assign gmap = gmap_q;
endmodule

// File: rtl/xbus_gdec.sv
module xbus_gdec #(
    parameter int GW       = 8,
    parameter int AW       = 16,
    parameter int BLK_BITS = 4
) (
    input  logic [GW-1:0] gmap,
    input  logic [AW-1:0] addr,
    input  logic          is_io,
    output logic          glob
);
    localparam int NW   = BLK_BITS + 1;
    localparam int MAXB = 1 << (BLK_BITS - 1);
    localparam int NBLK = 1 << BLK_BITS;

    logic [NW-1:0] nblk, thresh, blk;

    always_comb begin
        nblk   = (gmap > GW'(MAXB)) ? NW'(MAXB) : NW'(gmap);
        thresh = NW'(NBLK) - nblk;
        blk    = {1'b0, addr[AW-1 -: BLK_BITS]};
        glob   = !is_io && (nblk != '0) && (blk >= thresh);
    end
endmodule

// File: rtl/xbus_pick.sv
module xbus_pick #(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        any = |req;
    end
endmodule

// File: rtl/xbus_sequencer.sv
module xbus_sequencer
    import xbus_pkg::*;
#(
    parameter int GW       = 8,
    parameter int BLK_BITS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gmap_we,
    input  logic [GW-1:0] gmap_wdata,
    input  logic          fetch_req,
    input  logic [AW-1:0] fetch_addr,
    input  logic          dread_req,
    input  logic [AW-1:0] dread_addr,
    input  logic          dread_io,
    input  logic          dwrite_req,
    input  logic [AW-1:0] dwrite_addr,
    input  logic [DW-1:0] dwrite_data,
    input  logic          dwrite_io,
    output logic          seq_busy,
    output logic          fetch_done,
    output logic [DW-1:0] fetch_rdata,
    output logic          dread_done,
    output logic [DW-1:0] dread_rdata,
    output logic          dwrite_done,
    output logic [AW-1:0] bus_addr,
    inout  wire  [DW-1:0] bus_data,
    output logic          ps_n,
    output logic          ds_n,
    output logic          is_n,
    output logic          rnw,
    output logic          strb_n,
    output logic          rd_n,
    output logic          we_n,
    output logic          br_n,
    input  logic          ready
);
    seq_t q, n;

    logic [GW-1:0]    gmap;
    logic [NSLOT-1:0] in_req;
    logic [SW-1:0]    in_idx, rest_idx;
    logic             in_any, rest_any;
    logic [NSLOT-1:0] rest;
    logic [1:0]       dglob;
    logic [AW-1:0]    daddr [2];
    logic             dio   [2];

    xbus_gmap #(.GW(GW)) u_gmap (
        .clk(clk), .rst_n(rst_n), .we(gmap_we), .wdata(gmap_wdata), .gmap(gmap)
    );

    assign daddr[0] = dwrite_addr;
    assign dio[0]   = dwrite_io;
    assign daddr[1] = dread_addr;
    assign dio[1]   = dread_io;

    for (genvar g = 0; g < 2; g++) begin : g_dec
        xbus_gdec #(.GW(GW), .AW(AW), .BLK_BITS(BLK_BITS)) u_dec (
            .gmap(gmap), .addr(daddr[g]), .is_io(dio[g]), .glob(dglob[g])
        );
    end

    assign in_req = {fetch_req, dread_req, dwrite_req};
    assign rest   = q.pend & ~(NSLOT'(1) << q.cur);

    xbus_pick #(.N(NSLOT), .IW(SW)) u_pick_in (
        .req(in_req), .idx(in_idx), .any(in_any)
    );
    xbus_pick #(.N(NSLOT), .IW(SW)) u_pick_rest (
        .req(rest), .idx(rest_idx), .any(rest_any)
    );

    slot_t cs;
    logic  act, is_wr, can_end;

    always_comb begin
        cs      = q.slot[q.cur];
        act     = (q.st == ST_BUS);
        is_wr   = (q.cur == SL_WR);
        can_end = !cs.glob || ready;
    end

    always_comb begin
        n      = q;
        n.done = '0;
        unique case (q.st)
            ST_IDLE: begin
                if (in_any) begin
                    n.slot[SL_WR] = '{addr: dwrite_addr, io: dwrite_io, glob: dglob[0]};
                    n.slot[SL_RD] = '{addr: dread_addr,  io: dread_io,  glob: dglob[1]};
                    n.slot[SL_FE] = '{addr: fetch_addr,  io: 1'b0,      glob: 1'b0};
                    n.pend  = in_req;
                    n.wdata = dwrite_data;
                    n.cur   = in_idx;
                    n.ph    = 1'b0;
                    n.st    = ST_BUS;
                end
            end
            ST_BUS: begin
                if (is_wr && !q.ph) begin
                    n.ph = 1'b1;
                end else if (can_end) begin
                    n.done[q.cur] = 1'b1;
                    if (q.cur == SL_RD) n.rd_data = bus_data;
                    if (q.cur == SL_FE) n.fe_data = bus_data;
                    n.pend = rest;
                    n.ph   = 1'b0;
                    if (rest_any) n.cur = rest_idx;
                    else          n.st  = ST_IDLE;
                end
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign seq_busy    = act;
    assign dwrite_done = q.done[SL_WR];
    assign dread_done  = q.done[SL_RD];
    assign fetch_done  = q.done[SL_FE];
    assign dread_rdata = q.rd_data;
    assign fetch_rdata = q.fe_data;

    always_comb begin
        bus_addr = act ? cs.addr : '0;
        strb_n   = !act;
        ps_n     = !(act && q.cur == SL_FE);
        ds_n     = !(act && q.cur != SL_FE && !cs.io);
        is_n     = !(act && q.cur != SL_FE && cs.io);
        rnw      = !(act && is_wr);
        rd_n     = !(act && !is_wr);
        we_n     = !(act && is_wr && q.ph);
        br_n     = !(act && cs.glob);
    end

    assign bus_data = (act && is_wr) ? q.wdata : 'z;

    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        strb_n |-> (ps_n && ds_n && is_n && rd_n && we_n && br_n));

    assert_one_space_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_n |-> ($countones({ps_n, ds_n, is_n}) == 2));

    assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !we_n));

    assert_we_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> ($past(!strb_n) && $past(!rnw) && $past(we_n)));

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fetch_done, dread_done, dwrite_done}));

    assert_wait_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_n && !br_n && !ready && (!rd_n || !we_n)) |=> (!strb_n && $stable(bus_addr)));

    assert_slot_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> (q.cur != 2'd3));
endmodule

// File: tb/xbus_sequencer_test.sv
`timescale 1ns/1ps
module xbus_sequencer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gmap_we = 1'b0;
    logic [7:0]  gmap_wdata = '0;
    logic        fetch_req = 1'b0, dread_req = 1'b0, dwrite_req = 1'b0;
    logic [15:0] fetch_addr = '0, dread_addr = '0, dwrite_addr = '0, dwrite_data = '0;
    logic        dread_io = 1'b0, dwrite_io = 1'b0;
    logic        seq_busy, fetch_done, dread_done, dwrite_done;
    logic [15:0] fetch_rdata, dread_rdata, bus_addr;
    wire  [15:0] bus_data;
    logic        ps_n, ds_n, is_n, rnw, strb_n, rd_n, we_n, br_n;
    logic        ready = 1'b0;

    int n_run = 0, n_fail = 0, cyc = 0, need = 0, wcnt = 0;

    int          lg_n;
    int          lg_cyc [64];
    int          lg_k   [64];
    logic [15:0] lg_addr[64];
    logic [15:0] lg_data[64];
    logic        lg_io  [64];
    logic        lg_br  [64];
    logic        lg_we  [64];
    int          wd_c, rd_c, fd_c, fd_n;

    xbus_sequencer uut (
        .clk(clk), .rst_n(rst_n), .gmap_we(gmap_we), .gmap_wdata(gmap_wdata),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .dread_req(dread_req), .dread_addr(dread_addr), .dread_io(dread_io),
        .dwrite_req(dwrite_req), .dwrite_addr(dwrite_addr), .dwrite_data(dwrite_data),
        .dwrite_io(dwrite_io), .seq_busy(seq_busy),
        .fetch_done(fetch_done), .fetch_rdata(fetch_rdata),
        .dread_done(dread_done), .dread_rdata(dread_rdata), .dwrite_done(dwrite_done),
        .bus_addr(bus_addr), .bus_data(bus_data), .ps_n(ps_n), .ds_n(ds_n), .is_n(is_n),
        .rnw(rnw), .strb_n(strb_n), .rd_n(rd_n), .we_n(we_n), .br_n(br_n), .ready(ready)
    );

    always #2.5 clk = ~clk;

    function automatic logic [15:0] model(input logic [15:0] a, input logic p, input logic io);
        if (p)  return a ^ 16'hA5A5;
        if (io) return a ^ 16'h0F0F;
        return a ^ 16'h3C00;
    endfunction

    assign bus_data = (!rd_n) ? model(bus_addr, !ps_n, !is_n) : 16'bz;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 40000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: run hung, cycle %0d expected below 40000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (!strb_n && lg_n < 64) begin
            lg_cyc[lg_n]  = cyc;
            lg_k[lg_n]    = !ps_n ? 2 : (!rnw ? 0 : 1);
            lg_addr[lg_n] = bus_addr;
            lg_data[lg_n] = bus_data;
            lg_io[lg_n]   = !is_n;
            lg_br[lg_n]   = !br_n;
            lg_we[lg_n]   = !we_n;
            lg_n++;
        end
        if (dwrite_done) wd_c = cyc;
        if (dread_done)  rd_c = cyc;
        if (fetch_done) begin fd_c = cyc; fd_n++; end
        if (!br_n) begin ready = (wcnt >= need); wcnt++; end
        else begin ready = 1'b0; wcnt = 0; end
    end

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic set_gmap(input logic [7:0] v);
        @(negedge clk); gmap_we = 1'b1; gmap_wdata = v;
        @(negedge clk); gmap_we = 1'b0;
    endtask

    task automatic batch(input bit w, input logic [15:0] wa, input logic [15:0] wd, input bit wio,
                         input bit r, input logic [15:0] ra, input bit rio,
                         input bit f, input logic [15:0] fa, input int nd, input bit poke);
        @(negedge clk);
        lg_n = 0; wd_c = -1; rd_c = -1; fd_c = -1; fd_n = 0; need = nd;
        dwrite_req = w; dwrite_addr = wa; dwrite_data = wd; dwrite_io = wio;
        dread_req = r; dread_addr = ra; dread_io = rio;
        fetch_req = f; fetch_addr = fa;
        @(negedge clk);
        dwrite_req = 1'b0; dread_req = 1'b0; fetch_req = 1'b0;
        if (poke) begin
            fetch_req = 1'b1; fetch_addr = 16'h7777;
            @(negedge clk);
            chk(seq_busy === 1'b1, "R10", "busy during batch", seq_busy, 1);
            @(negedge clk);
            fetch_req = 1'b0;
        end
        for (int i = 0; i < 50 && seq_busy; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(strb_n && ps_n && ds_n && is_n && rd_n && we_n && br_n, "R1", "idle controls",
            {strb_n, ps_n, ds_n, is_n, rd_n, we_n, br_n}, 7'h7f);
        chk(!seq_busy && !fetch_done && !dread_done && !dwrite_done, "R1", "busy/done",
            {seq_busy, fetch_done, dread_done, dwrite_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        batch(0, 0, 0, 0, 1, 16'hFFFF, 0, 0, 0, 0, 0);
        chk(lg_n == 1 && !lg_br[0], "R1", "gmap cleared, 0xFFFF not global", lg_br[0], 0);
    endtask

    task automatic t_all_three;
        int c0;
        batch(1, 16'h3456, 16'hBEEF, 0, 1, 16'h2345, 0, 1, 16'h0100, 0, 0);
        c0 = lg_cyc[0];
        chk(lg_n == 4, "R2", "bus cycles", lg_n, 4);
        chk(lg_k[0] == 0 && lg_k[1] == 0 && lg_k[2] == 1 && lg_k[3] == 2, "R2", "order",
            lg_k[2] * 16 + lg_k[3], 'h12);
        chk(lg_cyc[3] == c0 + 3, "R2", "back to back", lg_cyc[3] - c0, 3);
        chk(!lg_we[0] && lg_we[1], "R5", "we_n only in second cycle", {lg_we[0], lg_we[1]}, 1);
        chk(lg_data[0] == 16'hBEEF && lg_data[1] == 16'hBEEF && lg_addr[1] == 16'h3456,
            "R5", "write data/addr", lg_data[1], 16'hBEEF);
        chk(wd_c == c0 + 2, "R5", "write done cycle", wd_c - c0, 2);
        chk(rd_c == c0 + 3, "R4", "read done cycle", rd_c - c0, 3);
        chk(fd_c == c0 + 4, "R4", "fetch done cycle", fd_c - c0, 4);
        chk(dread_rdata == model(16'h2345, 0, 0), "R4", "read data held", dread_rdata, model(16'h2345, 0, 0));
        chk(fetch_rdata == model(16'h0100, 1, 0), "R6", "fetch from program space", fetch_rdata, model(16'h0100, 1, 0));
        chk(!lg_br[2], "R9", "ready low ignored on non-global read", lg_n, 4);
    endtask

    task automatic t_skip;
        int c0;
        batch(1, 16'h0010, 16'h1234, 0, 0, 0, 0, 1, 16'h0200, 0, 0);
        c0 = lg_cyc[0];
        chk(lg_n == 3 && lg_k[2] == 2 && lg_cyc[2] == c0 + 2, "R3", "fetch follows write",
            lg_cyc[2] - c0, 2);
        chk(fd_c == c0 + 3, "R3", "fetch done", fd_c - c0, 3);
        batch(0, 0, 0, 0, 1, 16'h0321, 0, 0, 0, 0, 0);
        chk(lg_n == 1 && lg_k[0] == 1, "R3", "lone read", lg_n, 1);
    endtask

    task automatic t_io;
        batch(1, 16'h0041, 16'hCAFE, 1, 1, 16'h0040, 1, 0, 0, 0, 0);
        chk(lg_n == 3 && lg_io[0] && lg_io[2], "R6", "I/O select", lg_n, 3);
        chk(lg_data[1] == 16'hCAFE, "R6", "I/O write data", lg_data[1], 16'hCAFE);
        chk(dread_rdata == model(16'h0040, 0, 1), "R6", "I/O read data", dread_rdata, model(16'h0040, 0, 1));
    endtask

    task automatic t_global;
        int c0;
        set_gmap(8'd2);
        batch(1, 16'hD000, 16'h5555, 0, 1, 16'hE123, 0, 0, 0, 3, 0);
        c0 = lg_cyc[0];
        chk(lg_n == 6, "R9", "global read waits", lg_n, 6);
        chk(!lg_br[0] && !lg_br[1], "R7", "0xD000 not global at N=2", lg_br[1], 0);
        chk(lg_br[2] && lg_br[3] && lg_br[4] && lg_br[5], "R8", "br_n held low", lg_br[5], 1);
        chk(lg_addr[5] == 16'hE123, "R9", "address held", lg_addr[5], 16'hE123);
        chk(rd_c == c0 + 6, "R9", "read done after ready", rd_c - c0, 6);
        batch(1, 16'hF000, 16'h6666, 0, 0, 0, 0, 1, 16'hFFFF, 3, 0);
        chk(lg_n == 5 && lg_we[1] && lg_we[3] && lg_br[0], "R9", "global write waits", lg_n, 5);
        chk(!lg_br[4] && lg_k[4] == 2, "R7", "fetch never global", lg_br[4], 0);
    endtask

    task automatic t_clamp;
        set_gmap(8'd20);
        batch(1, 16'h7FFF, 16'h0001, 0, 1, 16'h8000, 0, 0, 0, 0, 0);
        chk(lg_n == 3 && !lg_br[0] && lg_br[2], "R7", "clamp to upper half", {lg_br[0], lg_br[2]}, 1);
        set_gmap(8'd8);
        batch(0, 0, 0, 0, 1, 16'hFFFF, 1, 0, 0, 0, 0);
        chk(lg_n == 1 && !lg_br[0], "R7", "I/O never global", lg_br[0], 0);
        set_gmap(8'd0);
        batch(0, 0, 0, 0, 1, 16'hFFFF, 0, 0, 0, 0, 0);
        chk(lg_n == 1 && !lg_br[0], "R11", "zero mapping after rewrite", lg_br[0], 0);
    endtask

    task automatic t_busy;
        batch(1, 16'h0A00, 16'h0B0B, 0, 1, 16'h0C00, 0, 1, 16'h0D00, 0, 1);
        chk(lg_n == 4 && fd_n == 1, "R10", "new fetch dropped", lg_n, 4);
        chk(lg_addr[3] == 16'h0D00, "R10", "original fetch address", lg_addr[3], 16'h0D00);
    endtask

    initial begin
        t_reset();
        t_all_three();
        t_skip();
        t_io();
        t_global();
        t_clamp();
        t_busy();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule